// File: doc/BRIEF.md
# Saturating BCD Millisecond Race Timer

This block keeps elapsed race time as five decimal digits: tens and units of seconds, followed by tenths, hundredths and thousandths. It runs from the fast system clock. It steps forward by one thousandth of a second each time an internal cycle prescaler completes a full period. With the default of 50,000 cycles on a 50 MHz clock, that period is one millisecond. No slowed or divided clock is used anywhere.

Race sequencing logic drives two inputs. `clear` zeroes the digits and restarts the prescaler phase. `run` lets time advance. When the count reaches 14.999 s it stops there and raises `saturated`. It then holds that value until the next clear. Display encoding happens outside this block.

Top module: `race_timer`

## Requirements
- R1: Reset (`rst_n` low) and `clear` both force all five digits to 0 and `saturated` to 0. While `clear` is high the count stays at zero, even when `run` is also high.
- R2: After the cycle in which `clear` is sampled high, with `run` held high, the first increment arrives on the TICK_CYCLES-th rising edge. Each later increment arrives exactly TICK_CYCLES edges after the one before, and each one adds exactly one thousandth.
- R3: Every digit is a BCD value from 0 to 9. When a digit at 9 is incremented it goes to 0 and carries into the next higher digit on the same edge (for example 0.999 to 1.000, and 9.999 to 10.000).
- R4: While `run` is low, neither the digits nor the prescaler phase change. When `run` goes high again, counting resumes from the same phase.
- R5: The count stops at 14.999 and does not change after that, even while `run` stays high, until `clear` or reset.
- R6: `saturated` is 0 while the count is below 14.999. It goes to 1 on the same edge on which the count becomes 14.999.
- R7: The tens-of-seconds digit never goes above 1.
- R8: A clear after saturation restarts counting from 0.000 with the normal first-increment timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of the count, the flag and the prescaler phase |
| run | input | 1 | Enables time to advance |
| sec_tens | output | 4 | Tens of seconds (BCD) |
| sec_ones | output | 4 | Units of seconds (BCD) |
| frac_tenths | output | 4 | Tenths of a second (BCD) |
| frac_hundredths | output | 4 | Hundredths of a second (BCD) |
| frac_thousandths | output | 4 | Thousandths of a second (BCD) |
| saturated | output | 1 | Count is held at 14.999 |

## Verification
The bench checks the cycle of the first increment after a clear. A prescaler that is not restarted by clear, or that is off by one, shifts that increment by a cycle. It pauses `run` partway through a prescaler period and checks that the next step still comes after the remaining cycles. A design that resets or loses its phase on a pause fails that check. It drives the two cascaded rollovers at 0.999 and 9.999, where a missing same-edge carry produces values such as 0.990 or 9.000. It also checks the edge at 14.998 to 14.999, where a design that wraps, skips the limit or sets the flag a cycle late is caught.

// File: rtl/race_timer_pkg.sv
package race_timer_pkg;
  localparam int unsigned NDIG = 5;
  typedef logic [3:0] bcd_t;
  typedef logic [NDIG-1:0][3:0] bcd_word_t;

  // Index 0 is thousandths; index 4 is tens of seconds.
  localparam bcd_word_t LIMIT_WORD = {4'd1, 4'd4, 4'd9, 4'd9, 4'd9};
  localparam bcd_word_t PRE_LIMIT  = {4'd1, 4'd4, 4'd9, 4'd9, 4'd8};

  function automatic bcd_t bcd_step(input bcd_t d);
    return (d == 4'd9) ? 4'd0 : d + 4'd1;
  endfunction

  function automatic logic bcd_full(input bcd_t d);
    return d == 4'd9;
  endfunction

  function automatic int unsigned word_to_ms(input bcd_word_t w);
    int unsigned acc;
    acc = 0;
    for (int i = NDIG - 1; i >= 0; i--) acc = acc * 10 + int'(w[i]);
    return acc;
  endfunction
endpackage

// File: rtl/ms_prescaler.sv
module ms_prescaler #(
  parameter int unsigned TICK_CYCLES = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] phase_q;
  logic          at_last;

  assign at_last = (phase_q == LAST);
  assign tick    = run & ~clear & at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         phase_q <= '0;
    else if (clear)     phase_q <= '0;
    else if (run) begin
      if (at_last)      phase_q <= '0;
      else              phase_q <= phase_q + CW'(1);
    end
  end
endmodule

// File: rtl/bcd_digit.sv
module bcd_digit
  import race_timer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic inc,
  output bcd_t value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     value <= '0;
    else if (clear) value <= '0;
    else if (inc)   value <= bcd_step(value);
  end
endmodule

// File: rtl/race_timer.sv
module race_timer
  import race_timer_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       run,
  output logic [3:0] sec_tens,
  output logic [3:0] sec_ones,
  output logic [3:0] frac_tenths,
  output logic [3:0] frac_hundredths,
  output logic [3:0] frac_thousandths,
  output logic       saturated
);
  // Named internal events, observed by the bound checker.
  logic            tick;
  logic            advance;
  logic [NDIG-1:0] carry;
  bcd_word_t       dig_q;
  logic            sat_q;
  logic            hit_limit;

  ms_prescaler #(.TICK_CYCLES(TICK_CYCLES)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear),
    .run   (run),
    .tick  (tick)
  );

  assign advance   = tick & ~sat_q;
  assign hit_limit = advance & (dig_q == PRE_LIMIT);

  assign carry[0] = advance;
  for (genvar i = 1; i < NDIG; i++) begin : g_carry
    assign carry[i] = carry[i-1] & bcd_full(dig_q[i-1]);
  end

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    bcd_digit u_dig (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (clear),
      .inc   (carry[i]),
      .value (dig_q[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sat_q <= 1'b0;
    else if (clear)     sat_q <= 1'b0;
    else if (hit_limit) sat_q <= 1'b1;
  end

  assign frac_thousandths = dig_q[0];
  assign frac_hundredths  = dig_q[1];
  assign frac_tenths      = dig_q[2];
  assign sec_ones         = dig_q[3];
  assign sec_tens         = dig_q[4];
  assign saturated        = sat_q;
endmodule

// File: rtl/race_timer_chk.sv
module race_timer_chk
  import race_timer_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      clear,
  input logic      run,
  input logic      tick,
  input logic      advance,
  input bcd_word_t dig_q,
  input logic      sat_q
);
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (dig_q == '0) && !sat_q);                                   // R1

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !clear) |=> word_to_ms(dig_q) == word_to_ms($past(dig_q)) + 1); // R2

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !tick) |=> $stable(dig_q));                                // R2

  AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_q[0] <= 4'd9) && (dig_q[1] <= 4'd9) && (dig_q[2] <= 4'd9) && (dig_q[3] <= 4'd9)); // R3

  AST_NO_TICK_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);                                                      // R4

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_q && !clear) |=> $stable(dig_q) && sat_q);                       // R5

  AST_SAT_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    sat_q |-> (dig_q == LIMIT_WORD));                                     // R6

  AST_LIMIT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_q == LIMIT_WORD) |-> sat_q);                                     // R6

  AST_TENS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    dig_q[4] <= 4'd1);                                                    // R7
endmodule

bind race_timer race_timer_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .clear   (clear),
  .run     (run),
  .tick    (tick),
  .advance (advance),
  .dig_q   (dig_q),
  .sat_q   (sat_q)
);

// File: tb/race_timer_bench.sv
module race_timer_bench;
  localparam int unsigned N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0;
  logic run = 1'b0;
  logic [3:0] d_t, d_o, d_10, d_100, d_1000;
  logic sat;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  race_timer #(.TICK_CYCLES(N)) u_race_timer (
    .clk(clk), .rst_n(rst_n), .clear(clear), .run(run),
    .sec_tens(d_t), .sec_ones(d_o), .frac_tenths(d_10),
    .frac_hundredths(d_100), .frac_thousandths(d_1000), .saturated(sat)
  );

  function automatic int shown_ms();
    return d_t * 10000 + d_o * 1000 + d_10 * 100 + d_100 * 10 + d_1000;
  endfunction

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    cycles(3);
    check("R1 reset count", shown_ms(), 0);
    check("R1 reset flag", sat, 0);
    rst_n = 1'b1;
    cycles(1);
  endtask

  task automatic t_first_step;
    clear = 1'b1; run = 1'b1;
    cycles(1);
    clear = 1'b0;
    cycles(N - 1);
    check("R2 before first step", shown_ms(), 0);
    cycles(1);
    check("R2 first step", shown_ms(), 1);
    cycles(N);
    check("R2 second step", shown_ms(), 2);
  endtask

  task automatic t_clear_priority_and_pause;
    clear = 1'b1; run = 1'b1;
    cycles(10);
    check("R1 clear over run", shown_ms(), 0);
    clear = 1'b0;
    cycles(N / 2);
    run = 1'b0;
    cycles(10);
    check("R4 paused count", shown_ms(), 0);
    run = 1'b1;
    cycles(N - N / 2 - 1);
    check("R4 phase kept before", shown_ms(), 0);
    cycles(1);
    check("R4 phase kept step", shown_ms(), 1);
  endtask

  task automatic t_rollovers;
    cycles((999 - 1) * N);
    check("R3 at 0.999", shown_ms(), 999);
    cycles(N);
    check("R3 carry to 1.000", shown_ms(), 1000);
    check("R3 ones digit", d_o, 1);
    check("R3 thousandths digit", d_1000, 0);
    cycles((9999 - 1000) * N);
    check("R3 at 9.999", shown_ms(), 9999);
    cycles(N);
    check("R3 carry to 10.000", shown_ms(), 10000);
    check("R7 tens digit 1", d_t, 1);
    check("R3 ones after carry", d_o, 0);
  endtask

  task automatic t_saturate;
    cycles((14998 - 10000) * N);
    check("R6 count 14.998", shown_ms(), 14998);
    check("R6 flag low below limit", sat, 0);
    cycles(N);
    check("R5 reach 14.999", shown_ms(), 14999);
    check("R6 flag with limit", sat, 1);
    cycles(50 * N);
    check("R5 held at limit", shown_ms(), 14999);
    check("R5 flag held", sat, 1);
    check("R7 tens capped", d_t, 1);
  endtask

  task automatic t_restart;
    clear = 1'b1;
    cycles(1);
    clear = 1'b0;
    check("R8 cleared count", shown_ms(), 0);
    check("R8 cleared flag", sat, 0);
    cycles(N - 1);
    check("R8 before restart step", shown_ms(), 0);
    cycles(1);
    check("R8 restart step", shown_ms(), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_first_step();
    t_clear_priority_and_pause();
    t_rollovers();
    t_saturate();
    t_restart();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule